// File: doc/BRIEF.md
# Audio Bit Clock Generator

This block produces the bit clock for one audio serial port. A 5-bit source code chooses the source. It can forward an external bit clock, pass the master audio clock through, or divide the master clock by one ratio from a fixed ladder: 2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256 or 384. Every output is produced in the master clock domain. The output is a level `bclk` that downstream logic can treat as the bit clock, plus a one-cycle strobe `bclk_en` that marks each rising edge of `bclk`. The serial logic that consumes the bit clock can therefore run on the master clock with a clock enable. It needs no derived clock net.

One copy of the block serves each interface. The parameter `IFACE_ID` decides which of the two external bit clock pins code 0 forwards. All other codes behave the same way in both copies. Unused codes silence the output.

When the source code changes, the divider restarts from zero. The output spends exactly one master cycle low and with no strobe, and then begins the new ratio at the start of a high phase. Every high and low phase therefore lasts a whole number of master cycles, at least one.

Top module: `abclk_gen`

## Requirements
- R1: While reset is asserted, and for the first three master cycles after `rst_n` is released, `bclk` and `bclk_en` are both 0.
- R2: Code 0x01 selects divisor 1. After the restart cycle, `bclk_en` is 1 in every master cycle and `bclk` stays 1.
- R3: Codes 0x02 through 0x11 select divisors 2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256 and 384, in that order. The bit clock period is that many master cycles. The divisor for code c (where c ≥ 2) is (2 if c−2 is even, else 3) shifted left by (c−2)/2.
- R4: For an even divisor N, `bclk` is 1 for the first N/2 cycles of each period and 0 for the remaining N/2.
- R5: For divisor 3 (code 0x03), `bclk` is 1 for one cycle and 0 for two cycles in each period.
- R6: `bclk_en` is 1 for exactly the cycles in which `bclk` goes from 0 to 1. It is never 1 while `bclk` is 0, and it never stays high across a high phase longer than one cycle.
- R7: Code 0x00 forwards external bit clock 1 when `IFACE_ID` is 1 and external bit clock 2 when `IFACE_ID` is 2. The other external input has no effect on the outputs.
- R8: With code 0x00, `bclk` equals the selected external input delayed by three master cycles (two synchronizer stages plus the output register). `bclk_en` is 1 in each cycle where that delayed value rises.
- R9: Codes 0x12 through 0x1F hold `bclk` at 0 and never raise `bclk_en`.
- R10: In the cycle after `src_code` first differs from the code in use, `bclk` and `bclk_en` are both 0. In the following cycle, phase 0 of the new source begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_code | input | 5 | Bit clock source select code |
| ext_bclk1 | input | 1 | External bit clock 1, asynchronous |
| ext_bclk2 | input | 1 | External bit clock 2, asynchronous |
| bclk | output | 1 | Bit clock level, registered |
| bclk_en | output | 1 | One-cycle strobe on each rising edge of `bclk` |

## Verification
The bench sweeps every valid code, including the ones just below and above the ladder's ends. It compares each output cycle against a period and duty computed from the code arithmetic. A misplaced entry in the ladder would show up as the wrong period. A wrong half-period, especially for the odd divisor 3, would show up as a wrong duty. Each switch between codes lands at whatever phase the previous ratio had reached, so a divider that did not restart would be caught: it would skip the one quiet cycle or start the new ratio mid-phase. With code 0 the two external pins carry different patterns, which exposes a copy that forwards the wrong pin or gets the synchronizer latency wrong.

// File: rtl/abclk_pkg.sv
package abclk_pkg;

  localparam int CODE_W        = 5;
  localparam int CNT_W         = 9;
  localparam int LAST_DIV_CODE = 17;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_DIV = 2'd1,
    SRC_OFF = 2'd2
  } src_kind_e;

  function automatic src_kind_e kind_of(input logic [CODE_W-1:0] code);
    if (code == '0)
      return SRC_EXT;
    else if (code <= CODE_W'(LAST_DIV_CODE))
      return SRC_DIV;
    else
      return SRC_OFF;
  endfunction

  // Ladder: code 1 -> 1; code c >= 2 -> (2 or 3) << ((c-2)/2), alternating base.
  function automatic logic [CNT_W-1:0] divisor_of(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] step;
    logic [CNT_W-1:0]  base;
    if (code < CODE_W'(2)) begin
      return CNT_W'(1);
    end
    step = code - CODE_W'(2);
    base = step[0] ? CNT_W'(3) : CNT_W'(2);
    return base << (step >> 1);
  endfunction

endpackage

// File: rtl/abclk_rst_sync.sv
module abclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/abclk_ext_sync.sv
module abclk_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign sync_out = shift_q[STAGES-1];

endmodule

// File: rtl/abclk_div_core.sv
module abclk_div_core #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] divisor,
  output logic [CNT_W-1:0] phase
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_end;

  assign at_end = (cnt_q == divisor - CNT_W'(1));
  assign cnt_en = clr | run;

  always_comb begin
    if (clr || !run) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign phase = cnt_q;

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |-> (cnt_q < divisor)); // R3

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && at_end) |=> (cnt_q == '0)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/abclk_gen.sv
module abclk_gen
  import abclk_pkg::*;
#(
  parameter int IFACE_ID    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] src_code,
  input  logic              ext_bclk1,
  input  logic              ext_bclk2,
  output logic              bclk,
  output logic              bclk_en
);

  localparam logic          USE_EXT2  = (IFACE_ID == 2);
  localparam logic [CODE_W-1:0] CODE_RST = '1;

  logic              arst_n;
  logic              ext_raw;
  logic              ext_s;
  logic [CODE_W-1:0] code_q;
  logic              code_chg;
  src_kind_e         kind;
  logic [CNT_W-1:0]  div_n;
  logic [CNT_W-1:0]  half_n;
  logic [CNT_W-1:0]  phase;
  logic              bclk_q;
  logic              bclk_d;
  logic              en_q;
  logic              en_d;

  abclk_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (arst_n)
  );

  assign ext_raw = USE_EXT2 ? ext_bclk2 : ext_bclk1;

  abclk_ext_sync #(
    .STAGES (SYNC_STAGES)
  ) u_ext_sync (
    .clk      (clk),
    .rst_n    (arst_n),
    .async_in (ext_raw),
    .sync_out (ext_s)
  );

  // Active code register, loaded only on a change
  assign code_chg = (src_code != code_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      code_q <= CODE_RST;
    end else if (code_chg) begin
      code_q <= src_code;
    end
  end

  assign kind   = kind_of(code_q);
  assign div_n  = divisor_of(code_q);
  assign half_n = div_n >> 1;

  abclk_div_core #(
    .CNT_W (CNT_W)
  ) u_div_core (
    .clk     (clk),
    .rst_n   (arst_n),
    .clr     (code_chg),
    .run     (kind == SRC_DIV),
    .divisor (div_n),
    .phase   (phase)
  );

  // Output next-state
  always_comb begin
    bclk_d = 1'b0;
    en_d   = 1'b0;
    if (!code_chg) begin
      unique case (kind)
        SRC_DIV: begin
          bclk_d = (div_n == CNT_W'(1)) || (phase < half_n);
          en_d   = (phase == '0);
        end
        SRC_EXT: begin
          bclk_d = ext_s;
          en_d   = ext_s & ~bclk_q;
        end
        default: begin
          bclk_d = 1'b0;
          en_d   = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      bclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_d;
      en_q   <= en_d;
    end
  end

  assign bclk    = bclk_q;
  assign bclk_en = en_q;

  AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!arst_n)
    code_chg |=> (!bclk_q && !en_q)); // R10

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!arst_n)
    (!code_chg && kind == SRC_OFF) |=> (!bclk_q && !en_q)); // R9

  AST_EN_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!arst_n)
    en_q |-> bclk_q); // R6

  AST_RISE_GIVES_EN: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(bclk_q) |-> en_q); // R6

  AST_UNDIVIDED_EVERY: assert property (@(posedge clk) disable iff (!arst_n)
    (!code_chg && code_q == CODE_W'(1)) |=> (bclk_q && en_q)); // R2

endmodule

// File: tb/abclk_gen_tb.sv
module abclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] code;
  logic       ext1;
  logic       ext2;
  logic       b1, e1, b2, e2;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  abclk_gen #(.IFACE_ID(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_code(code),
    .ext_bclk1(ext1), .ext_bclk2(ext2), .bclk(b1), .bclk_en(e1)
  );

  abclk_gen #(.IFACE_ID(2)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .src_code(code),
    .ext_bclk1(ext1), .ext_bclk2(ext2), .bclk(b2), .bclk_en(e2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ladder(input int c);
    if (c == 1) return 1;
    return (((c - 2) % 2) == 0 ? 2 : 3) << ((c - 2) / 2);
  endfunction

  // Runs one code for n cycles and compares both copies against the arithmetic model
  task automatic run_code(input int c, input int n);
    int nd;
    int bad_b1, bad_e1, bad_b2, bad_e2;
    string tag_b, tag_e;
    bit reserved;
    reserved = (c >= 18);
    nd = reserved ? 0 : ladder(c);
    bad_b1 = 0; bad_e1 = 0; bad_b2 = 0; bad_e2 = 0;
    @(negedge clk);
    code = 5'(c);
    for (int i = 0; i < n; i++) begin
      bit xb, xe;
      int p;
      @(negedge clk);
      if (reserved || i == 0) begin
        xb = 1'b0; xe = 1'b0;
      end else begin
        p  = (i - 1) % nd;
        xb = (nd == 1) ? 1'b1 : (p < nd / 2);
        xe = (p == 0);
      end
      if (i == 0) begin
        chk(!b1 && !e1, "R10 quiet cycle iface1", {b1, e1}, 0);
        chk(!b2 && !e2, "R10 quiet cycle iface2", {b2, e2}, 0);
      end else begin
        if (b1 != xb) bad_b1++;
        if (e1 != xe) bad_e1++;
        if (b2 != xb) bad_b2++;
        if (e2 != xe) bad_e2++;
      end
    end
    if (reserved)     tag_b = "R9 bclk";
    else if (nd == 1) tag_b = "R2 bclk";
    else if (nd == 3) tag_b = "R5 bclk";
    else              tag_b = "R3 R4 bclk";
    tag_e = reserved ? "R9 strobe" : "R6 strobe";
    chk(bad_b1 == 0, {tag_b, " iface1 mismatching cycles"}, bad_b1, 0);
    chk(bad_b2 == 0, {tag_b, " iface2 mismatching cycles"}, bad_b2, 0);
    chk(bad_e1 == 0, {tag_e, " iface1 mismatching cycles"}, bad_e1, 0);
    chk(bad_e2 == 0, {tag_e, " iface2 mismatching cycles"}, bad_e2, 0);
  endtask

  task automatic run_ext();
    bit h1 [0:79];
    bit h2 [0:79];
    int bad_b1, bad_e1, bad_b2, bad_e2;
    bad_b1 = 0; bad_e1 = 0; bad_b2 = 0; bad_e2 = 0;
    @(negedge clk);
    code = 5'd0;
    ext1 = 1'b0;
    ext2 = 1'b0;
    repeat (6) @(negedge clk);
    for (int j = 0; j < 80; j++) begin
      bit x1, x1p, x2, x2p;
      @(negedge clk);
      x1  = (j >= 3) ? h1[j-3] : 1'b0;
      x1p = (j >= 4) ? h1[j-4] : 1'b0;
      x2  = (j >= 3) ? h2[j-3] : 1'b0;
      x2p = (j >= 4) ? h2[j-4] : 1'b0;
      if (b1 != x1)          bad_b1++;
      if (e1 != (x1 & ~x1p)) bad_e1++;
      if (b2 != x2)          bad_b2++;
      if (e2 != (x2 & ~x2p)) bad_e2++;
      h1[j] = ((j % 9) < 4);
      h2[j] = ((j % 5) < 2);
      ext1  = h1[j];
      ext2  = h2[j];
    end
    chk(bad_b1 == 0, "R7 R8 iface1 follows ext1, mismatching cycles", bad_b1, 0);
    chk(bad_e1 == 0, "R8 iface1 edge strobe, mismatching cycles", bad_e1, 0);
    chk(bad_b2 == 0, "R7 R8 iface2 follows ext2, mismatching cycles", bad_b2, 0);
    chk(bad_e2 == 0, "R8 iface2 edge strobe, mismatching cycles", bad_e2, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    code  = 5'd2;
    ext1  = 1'b0;
    ext2  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!b1 && !e1 && !b2 && !e2, "R1 outputs low in reset", {b1, e1, b2, e2}, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!b1 && !e1 && !b2 && !e2, "R1 outputs low after release", {b1, e1, b2, e2}, 0);
    end
    for (int c = 1; c <= 17; c++) begin
      run_code(c, 3 * ladder(c) + 4);
    end
    run_code(2, 9);
    run_code(1, 6);
    for (int c = 18; c <= 31; c++) begin
      run_code(c, 40);
    end
    run_code(3, 12);
    run_ext();
    run_code(4, 14);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule